// File: doc/BRIEF.md
# Programmable Serial Character Receiver

This block takes an asynchronous serial line and turns each frame on it into one parallel character with status flags. Its clock runs at sixteen times the bit rate. The line is treated as already synchronous to that clock, so any synchronizer stage belongs outside the block.

A frame has these parts, in order:
- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional parity bit;
- the stop time.

A control word sets the character length, whether parity is used, and which parity sense applies. The control word is captured while a load strobe is high.

When a frame completes, the character and its error flags are placed on the outputs. The data-ready flag follows one clock later and stays high until the consumer pulses the clear input. If a new character lands while data-ready is still high, the overrun flag is raised and the new character replaces the old one. The receiver starts looking for the next start bit at the centre of the first stop bit, so frames may follow each other with very short stop times.

Top module: `serial_char_rx`

## Requirements
- R1: While `rst` is high, all outputs are low and the receiver is idle. After reset the control word is length code 2'b11 (8 bits), parity off, even sense.
- R2: The clock edge that first sees the line low in the idle state is the detection edge, D. The start-bit centre is sampled at edge D+8. Bit k after the start bit is sampled at edge D+8+16k.
- R3: If the line is high at the start-bit centre, the candidate is discarded, the receiver returns to idle and no character is produced.
- R4: Length code `cfg_len` is 2'b00, 2'b01, 2'b10 or 2'b11, for 5, 6, 7 or 8 data bits. Data bits are taken least significant first into `rx_data` bit 0 upward. Bits of `rx_data` at or above the length read zero.
- R5: With `cfg_par_en`=1 the bit after the data is the parity bit. `cfg_par_odd`=1 selects odd parity and 0 selects even parity. `parity_err` is 1 when the data bits and the parity bit together do not match the selected parity.
- R6: With `cfg_par_en`=0 no parity bit is expected, the stop centre comes one bit after the last data bit, and `parity_err` is 0.
- R7: `framing_err` is 1 when the line is low at the centre of the first stop bit.
- R8: The first stop bit's centre is edge S, where S = D+8+16(N+P+1), N is the number of data bits and P is 1 with parity and 0 without. `rx_data`, `parity_err`, `framing_err` and `overrun_err` take their new values at edge S. `data_ready` rises at edge S+1.
- R9: A high `dr_clr` sampled at an edge clears `data_ready` at that edge, unless a character is being delivered at that edge.
- R10: `overrun_err` takes the value `data_ready` had at edge S. The new character replaces the previous one in `rx_data`.
- R11: The receiver is idle again from edge S+1, so a start bit beginning nine clocks into the stop bit is received.
- R12: The control word is captured on every edge where `cfg_load` is high. Changes to `cfg_len`, `cfg_par_en` and `cfg_par_odd` while `cfg_load` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Master reset, active high, synchronous |
| rx_line | input | 1 | Serial line, idle high |
| cfg_load | input | 1 | Control word capture strobe |
| cfg_len | input | 2 | Length code: 5 + code data bits |
| cfg_par_en | input | 1 | 1 = a parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| dr_clr | input | 1 | Clears data_ready |
| rx_data | output | 8 | Received character, zero above the length |
| data_ready | output | 1 | A character is waiting |
| parity_err | output | 1 | Parity mismatch on the last character |
| framing_err | output | 1 | Low stop centre on the last character |
| overrun_err | output | 1 | Last character arrived while data_ready was high |

## Verification
The hardest case to reach is the restart from the stop-bit centre. It needs a frame whose stop time is cut to nine clocks and followed at once by a new start bit. The stimulus builds each frame clock by clock, so the stop length is a free variable; the directed case uses nine clocks and the random frames use eleven to thirty-two. A framing-error frame keeps the line low past the stop centre, and because the receiver is idle again at that point, this also produces a false start that must be discarded. The noise-reject path is therefore exercised both by directed short pulses and by the random error frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } srx_state_e;

   // 1 when the data parity plus the parity bit fail the selected sense
   function automatic logic srx_parity_bad(input logic data_xor,
                                           input logic par_bit,
                                           input logic odd_sense);
      return (data_xor ^ par_bit) != odd_sense;
   endfunction

endpackage

// File: rtl/srx_cfg.sv
module srx_cfg #(
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LEN_W-1:0] len_in,
   input  logic             par_en_in,
   input  logic             par_odd_in,
   output logic [LEN_W-1:0] len_q,
   output logic             par_en_q,
   output logic             par_odd_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         len_q     <= '1;
         par_en_q  <= 1'b0;
         par_odd_q <= 1'b0;
      end else if (load) begin
         len_q     <= len_in;
         par_en_q  <= par_en_in;
         par_odd_q <= par_odd_in;
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(len_q) && $stable(par_en_q) && $stable(par_odd_q))); // R12

endmodule

// File: rtl/srx_timer.sv
module srx_timer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic half,
   output logic tick
);

   localparam int CNT_W = $clog2(OVS);
   localparam int HALF  = OVS / 2;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("srx_timer: OVS must be even and at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = half ? CNT_W'(HALF - 1) : CNT_W'(OVS - 1);
   assign tick  = active && (cnt == limit);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (!active || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/srx_seq.sv
module srx_seq #(
   parameter int MAXB  = 8,
   parameter int MINB  = 5,
   parameter int LEN_W = 2,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   input  logic             par_en,
   output logic             active,
   output logic             half,
   output logic             start_det,
   output logic             samp_data,
   output logic             samp_par,
   output logic             load,
   output logic [IDX_W-1:0] bit_idx
);
   import srx_pkg::*;

   srx_state_e       state;
   logic [IDX_W-1:0] last_idx;

   assign last_idx  = IDX_W'(MINB - 1) + IDX_W'(len);
   assign active    = (state != ST_IDLE);
   assign half      = (state == ST_START);
   assign start_det = (state == ST_IDLE) && !rx;
   assign samp_data = tick && (state == ST_DATA);
   assign samp_par  = tick && (state == ST_PARITY);
   assign load      = tick && (state == ST_STOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               bit_idx <= '0;
               if (!rx) state <= ST_START;
            end
            ST_START: if (tick) state <= rx ? ST_IDLE : ST_DATA;
            ST_DATA: if (tick) begin
               if (bit_idx == last_idx)
                  state <= par_en ? ST_PARITY : ST_STOP;
               else
                  bit_idx <= bit_idx + 1'b1;
            end
            ST_PARITY: if (tick) state <= ST_STOP;
            ST_STOP:   if (tick) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   AST_NOISE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_START && tick && rx) |=> (state == ST_IDLE && !load)); // R3
   AST_STOP_RESUMES: assert property (@(posedge clk) disable iff (rst)
      load |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/srx_assemble.sv
module srx_assemble #(
   parameter int MAXB  = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx,
   input  logic             start_det,
   input  logic             samp_data,
   input  logic             samp_par,
   input  logic             par_odd,
   input  logic [IDX_W-1:0] bit_idx,
   output logic [MAXB-1:0]  char_q,
   output logic             par_bad
);
   import srx_pkg::*;

   logic acc;

   generate
      for (genvar g = 0; g < MAXB; g++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst || start_det)
               char_q[g] <= 1'b0;
            else if (samp_data && bit_idx == IDX_W'(g))
               char_q[g] <= rx;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || start_det) begin
         acc     <= 1'b0;
         par_bad <= 1'b0;
      end else begin
         if (samp_data) acc <= acc ^ rx;
         if (samp_par)  par_bad <= srx_parity_bad(acc, rx, par_odd);
      end
   end

endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int MAXB = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [MAXB-1:0] char_in,
   input  logic            par_bad,
   input  logic            par_en,
   input  logic            rx,
   input  logic            dr_clr,
   output logic [MAXB-1:0] rx_data,
   output logic            data_ready,
   output logic            parity_err,
   output logic            framing_err,
   output logic            overrun_err
);

   logic load_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_data     <= '0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         overrun_err <= 1'b0;
         load_d      <= 1'b0;
         data_ready  <= 1'b0;
      end else begin
         load_d <= load;
         if (load) begin
            rx_data     <= char_in;
            parity_err  <= par_en && par_bad;
            framing_err <= !rx;
            overrun_err <= data_ready;
         end
         if (load_d)
            data_ready <= 1'b1;
         else if (dr_clr)
            data_ready <= 1'b0;
      end
   end

   AST_DR_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |-> ##2 data_ready); // R8
   AST_CLR_DROPS_DR: assert property (@(posedge clk) disable iff (rst)
      (dr_clr && !load_d) |=> !data_ready); // R9
   AST_OE_NEEDS_DR: assert property (@(posedge clk) disable iff (rst)
      $rose(overrun_err) |-> $past(data_ready)); // R10

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
   parameter int OVS   = 16,
   parameter int MAXB  = 8,
   parameter int MINB  = 5,
   parameter int LEN_W = $clog2(MAXB - MINB + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_line,
   input  logic             cfg_load,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   input  logic             dr_clr,
   output logic [MAXB-1:0]  rx_data,
   output logic             data_ready,
   output logic             parity_err,
   output logic             framing_err,
   output logic             overrun_err
);

   localparam int IDX_W = $clog2(MAXB);

   generate
      if (MINB < 1 || MAXB < MINB) begin : g_bad_len
         $error("serial_char_rx: need 1 <= MINB <= MAXB");
      end
      if ((MAXB - MINB + 1) > (1 << LEN_W)) begin : g_bad_code
         $error("serial_char_rx: LEN_W too narrow for the length range");
      end
   endgenerate

   logic [LEN_W-1:0] len_q;
   logic             par_en_q, par_odd_q;
   logic             tick, active, half, start_det, samp_data, samp_par, load;
   logic [IDX_W-1:0] bit_idx;
   logic [MAXB-1:0]  char_q;
   logic             par_bad;

   srx_cfg #(.LEN_W(LEN_W)) u_cfg (
      .clk(clk), .rst(rst), .load(cfg_load),
      .len_in(cfg_len), .par_en_in(cfg_par_en), .par_odd_in(cfg_par_odd),
      .len_q(len_q), .par_en_q(par_en_q), .par_odd_q(par_odd_q));

   srx_timer #(.OVS(OVS)) u_timer (
      .clk(clk), .rst(rst), .active(active), .half(half), .tick(tick));

   srx_seq #(.MAXB(MAXB), .MINB(MINB), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst(rst), .rx(rx_line), .tick(tick),
      .len(len_q), .par_en(par_en_q),
      .active(active), .half(half), .start_det(start_det),
      .samp_data(samp_data), .samp_par(samp_par), .load(load),
      .bit_idx(bit_idx));

   srx_assemble #(.MAXB(MAXB), .IDX_W(IDX_W)) u_asm (
      .clk(clk), .rst(rst), .rx(rx_line), .start_det(start_det),
      .samp_data(samp_data), .samp_par(samp_par), .par_odd(par_odd_q),
      .bit_idx(bit_idx), .char_q(char_q), .par_bad(par_bad));

   srx_status #(.MAXB(MAXB)) u_status (
      .clk(clk), .rst(rst), .load(load), .char_in(char_q),
      .par_bad(par_bad), .par_en(par_en_q), .rx(rx_line), .dr_clr(dr_clr),
      .rx_data(rx_data), .data_ready(data_ready), .parity_err(parity_err),
      .framing_err(framing_err), .overrun_err(overrun_err));

   logic [IDX_W:0] nbits;
   assign nbits = (IDX_W + 1)'(MINB) + (IDX_W + 1)'(len_q);

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      load |=> ((rx_data >> $past(nbits)) == '0)); // R4
   AST_NO_PE_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (rst)
      (load && !par_en_q) |=> !parity_err); // R6

endmodule

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic       cfg_load = 1'b0;
   logic [1:0] cfg_len = 2'b00;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       dr_clr = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready, parity_err, framing_err, overrun_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // bench model of the latched control word and of data_ready
   int m_len = 3;
   bit m_pe = 0;
   bit m_odd = 0;
   bit m_dr = 0;

   serial_char_rx uut (
      .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_load(cfg_load),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .dr_clr(dr_clr), .rx_data(rx_data), .data_ready(data_ready),
      .parity_err(parity_err), .framing_err(framing_err),
      .overrun_err(overrun_err));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit exp_par_bit(input logic [7:0] dm, input bit odd);
      return (^dm) ^ odd;
   endfunction

   task automatic idle(input int n);
      rx_line = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic load_cfg(input int len, input bit pe, input bit odd);
      @(negedge clk);
      cfg_len = 2'(len); cfg_par_en = pe; cfg_par_odd = odd; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      m_len = len; m_pe = pe; m_odd = odd;
   endtask

   task automatic clear_dr();
      @(negedge clk);
      dr_clr = 1'b1;
      @(negedge clk);
      dr_clr = 1'b0;
      m_dr = 0;
      chk("R9 dr_clr", data_ready, 0);
   endtask

   // one frame, one clock per step; load edge index L relative to start
   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                       input int stop_clks, input bit do_chk);
      int nb = 5 + m_len;
      int np = m_pe ? 1 : 0;
      int L = 8 + 16 * (nb + np + 1);
      int body = 16 * (1 + nb + np);
      int total = body + stop_clks;
      logic [7:0] dm = d & 8'((1 << nb) - 1);
      bit pbit = exp_par_bit(dm, m_odd) ^ bad_par;
      bit oe_exp = m_dr;
      for (int t = 0; t < total; t++) begin
         int seg = t / 16;
         logic lvl;
         @(negedge clk);
         if (do_chk && t == L + 1) begin
            chk("R4 data", rx_data, dm);
            chk(m_pe ? "R5 parity" : "R6 no parity", parity_err, m_pe && bad_par);
            chk("R7 framing", framing_err, bad_stop);
            chk("R10 overrun", overrun_err, oe_exp);
            chk("R8 dr delayed", data_ready, m_dr);
         end
         if (do_chk && t == L + 2)
            chk("R8 dr rise", data_ready, 1);
         if (seg == 0)                 lvl = 1'b0;
         else if (seg <= nb)           lvl = dm[seg-1];
         else if (np == 1 && seg == nb + 1) lvl = pbit;
         else                          lvl = (bad_stop && (t - body) < 12) ? 1'b0 : 1'b1;
         rx_line = lvl;
      end
      m_dr = 1;
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk("R1 reset dr", data_ready, 0);
      chk("R1 reset pe", parity_err, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset data", rx_data, 0);
      chk("R1 reset flags", {framing_err, overrun_err, data_ready}, 0);

      // R1 default control word: 8 bits, no parity
      send(8'hA5, 0, 0, 16, 1);
      idle(14);
      clear_dr();

      // R2 centre at D+8: a low of 8 clocks is rejected, 9 clocks is a start
      rx_line = 1'b0; repeat (8) @(negedge clk); idle(200);
      chk("R2 short low rejected", data_ready, 0);
      rx_line = 1'b0; repeat (9) @(negedge clk); idle(200);
      chk("R2 nine low accepted", data_ready, 1);
      chk("R2 all ones char", rx_data, 8'hFF);
      clear_dr();

      // R3 noise pulse then a good frame
      rx_line = 1'b0; repeat (5) @(negedge clk); idle(40);
      chk("R3 noise no char", data_ready, 0);
      send(8'h3C, 0, 0, 16, 1);
      idle(14);
      clear_dr();

      // R4 each length, R5 both senses, R7 framing
      load_cfg(0, 0, 0); send(8'hFF, 0, 0, 16, 1); idle(14); clear_dr();
      load_cfg(1, 1, 1); send(8'h2B, 0, 0, 16, 1); idle(14); clear_dr();
      load_cfg(2, 1, 0); send(8'h55, 1, 0, 16, 1); idle(14); clear_dr();
      load_cfg(3, 1, 1); send(8'h81, 1, 1, 16, 1); idle(14); clear_dr();

      // R12 inputs change without the strobe
      load_cfg(1, 1, 0);
      @(negedge clk); cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_par_odd = 1'b1;
      send(8'hE7, 0, 0, 16, 1); idle(14); clear_dr();

      // R10 overrun: two characters without clearing
      load_cfg(3, 0, 0);
      send(8'h11, 0, 0, 16, 1); idle(14);
      send(8'h22, 0, 0, 16, 1); idle(14);
      chk("R10 overwrite", rx_data, 8'h22);
      clear_dr();

      // R11 next start nine clocks into the stop bit
      send(8'h96, 0, 0, 9, 0);
      send(8'h69, 0, 0, 16, 1); idle(14);
      chk("R11 back to back", rx_data, 8'h69);
      clear_dr();

      // R1 master reset in mid-frame
      send(8'h5A, 0, 0, 16, 0); idle(5);
      rx_line = 1'b0; repeat (30) @(negedge clk);
      rst = 1'b1; rx_line = 1'b1;
      @(negedge clk); rst = 1'b0;
      m_len = 3; m_pe = 0; m_odd = 0; m_dr = 0;
      @(negedge clk);
      chk("R1 mid reset flags", {data_ready, overrun_err, framing_err, parity_err}, 0);
      chk("R1 mid reset data", rx_data, 0);
      idle(5);
      send(8'hC3, 0, 0, 16, 1); idle(14); clear_dr();

      // random frames
      for (int i = 0; i < 60; i++) begin
         logic [7:0] d = 8'($urandom);
         bit bp, bs;
         if ($urandom_range(0, 2) == 0)
            load_cfg($urandom_range(0, 3), 1'($urandom), 1'($urandom));
         bp = m_pe && ($urandom_range(0, 5) == 0);
         bs = ($urandom_range(0, 7) == 0);
         send(d, bp, bs, $urandom_range(11, 32), 1);
         idle(14);
         if ($urandom_range(0, 1) == 0) clear_dr();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule